// File: doc/BRIEF.md
# Serial DAC Front End with Double-Buffered Code Register

This block is the digital input stage of a 12-bit voltage-output converter, built as synchronous logic on a fast system clock. It watches five slow pins: an active-low select, a serial clock, a serial data line, an active-low load strobe and an active-low clear. Every pin passes through a two-flop synchroniser. Edges are then found on the system clock. The system clock must run at least four times faster than the serial clock.

Data moves through two registers. A 12-bit shift register takes in a word with the most significant bit first. The select and serial clock lines are interchangeable as the shift clock: a rising edge on either one advances the register while the other line is low.

The second register holds the converter code. It behaves as a level-sensitive latch. While the load strobe is low it follows the shift register, and when the strobe rises it keeps its value. The clear pin forces the code to zero. When clear is released, the load strobe decides what happens next. The block outputs the code and its value in millivolts, scaled by a parameter that defaults to 1 mV per step.

Top module: `serdac_front`

## Requirements
- R1: After reset, the code register and the shift register both hold 000h, and the millivolt output is 0.
- R2: Each rising edge of the serial clock while select is low shifts one data bit into the shift register. The first bit of a word ends up as bit 11 (most significant bit first).
- R3: A rising edge of select while the serial clock is low also shifts one bit into the shift register.
- R4: With select held high, toggling the serial clock leaves the shift register unchanged.
- R5: While load is low and clear is high, the code output follows the shift register after every shifted bit, whatever the state of select and the serial clock.
- R6: When load rises, the code register keeps its value. Further shifting with load high does not change the code.
- R7: While clear is low, the code is 000h whatever the state of load. Bits shifted in during this time are still kept in the shift register.
- R8: If load is low when clear is released, the code takes the shift register value at once. If load is high, the code stays 000h until load next goes low.
- R9: The millivolt output equals the code times 1 mV (straight binary): FFFh gives 4095, 800h gives 2048 and 000h gives 0.
- R10: The code output shows a shifted bit no later than four system clock cycles after the serial clock pin rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| sel_n_i | input | 1 | Active-low select pin |
| sck_i | input | 1 | Serial clock pin |
| sdi_i | input | 1 | Serial data pin, most significant bit first |
| load_n_i | input | 1 | Active-low load strobe; the code register is transparent while it is low |
| clear_n_i | input | 1 | Active-low clear of the code register |
| code_o | output | 12 | Current code held in the code register |
| mv_o | output | 16 | Output level in millivolts, derived from the code |

## Verification
The shift register cannot be read directly. A wrong value in it shows up only after load goes low, and then it appears on the code output within one system cycle of the synchronised strobe. The bench therefore opens the latch after every scenario that must leave the shift register untouched. A fault in the clear or load handling appears on the code output within three system cycles of the pin change. A wrong shift appears within four cycles while the latch is transparent. Tracking the code bit by bit with load low exposes an extra or missing shift at the exact bit where it happens.

// File: rtl/serdac_pkg.sv
package serdac_pkg;

  typedef struct packed {
    logic sel_n;
    logic sck;
    logic sdi;
    logic load_n;
    logic clear_n;
  } pin_t;

  localparam int PIN_W = $bits(pin_t);

  // Quiet levels of the pins: deselected, clock high, load and clear idle.
  localparam pin_t PIN_IDLE = '{sel_n: 1'b1, sck: 1'b1, sdi: 1'b0,
                                load_n: 1'b1, clear_n: 1'b1};

endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb stage_d[g] = d_i;
      end else begin : g_next
        always_comb stage_d[g] = stage_q[g-1];
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= RST_VAL;
        else         stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/serdac_shift_edge.sv
module serdac_shift_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_n_i,
  input  logic sck_i,
  output logic adv_o
);

  // Select and clock are interchangeable: the shift clock is their OR.
  logic merged_w;
  logic prev_q, prev_d;

  always_comb begin
    merged_w = sel_n_i | sck_i;
    prev_d   = merged_w;
    adv_o    = merged_w & ~prev_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= prev_d;
  end

endmodule

// File: rtl/serdac_shreg.sv
module serdac_shreg #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (adv_i) sh_d = {sh_q[W-2:0], bit_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '0;
    else if (adv_i) sh_q <= sh_d;
  end

  assign q_o = sh_q;

endmodule

// File: rtl/serdac_code_latch.sv
module serdac_code_latch #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_n_i,
  input  logic         clear_n_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] code_q, code_d;
  logic         upd_w;

  always_comb begin
    upd_w  = ~clear_n_i | ~load_n_i;
    code_d = code_q;
    if (!clear_n_i)     code_d = '0;
    else if (!load_n_i) code_d = src_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    code_q <= '0;
    else if (upd_w) code_q <= code_d;
  end

  assign q_o = code_q;

endmodule

// File: rtl/serdac_front.sv
module serdac_front #(
  parameter int W          = 12,
  parameter int MV_W       = 16,
  parameter int MV_PER_LSB = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_n_i,
  input  logic          sck_i,
  input  logic          sdi_i,
  input  logic          load_n_i,
  input  logic          clear_n_i,
  output logic [W-1:0]  code_o,
  output logic [MV_W-1:0] mv_o
);
  import serdac_pkg::*;

  localparam int SYNC_STAGES = 2;

  // Reset: asserted at once, released after two clock edges.
  logic rst_meta_q, rst_n_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  pin_t pins_raw, pins_s;
  logic [PIN_W-1:0] pins_s_vec;

  always_comb begin
    pins_raw.sel_n   = sel_n_i;
    pins_raw.sck     = sck_i;
    pins_raw.sdi     = sdi_i;
    pins_raw.load_n  = load_n_i;
    pins_raw.clear_n = clear_n_i;
  end

  serdac_sync #(
    .W      (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n_q),
    .d_i   (pins_raw),
    .q_o   (pins_s_vec)
  );

  assign pins_s = pin_t'(pins_s_vec);

  logic sel_s, sck_s, sdi_s, ld_s, clr_s;
  assign sel_s = pins_s.sel_n;
  assign sck_s = pins_s.sck;
  assign sdi_s = pins_s.sdi;
  assign ld_s  = pins_s.load_n;
  assign clr_s = pins_s.clear_n;

  logic adv_w;
  serdac_shift_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n_q),
    .sel_n_i(sel_s),
    .sck_i  (sck_s),
    .adv_o  (adv_w)
  );

  logic [W-1:0] shreg_q;
  serdac_shreg #(.W(W)) u_shreg (
    .clk_i (clk_i),
    .rst_ni(rst_n_q),
    .adv_i (adv_w),
    .bit_i (sdi_s),
    .q_o   (shreg_q)
  );

  logic [W-1:0] code_q;
  serdac_code_latch #(.W(W)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_q),
    .load_n_i (ld_s),
    .clear_n_i(clr_s),
    .src_i    (shreg_q),
    .q_o      (code_q)
  );

  assign code_o = code_q;
  assign mv_o   = MV_W'(code_q) * MV_W'(MV_PER_LSB);

endmodule

// File: rtl/serdac_chk.sv
module serdac_chk #(
  parameter int W = 12
) (
  input logic         clk_i,
  input logic         rst_n,
  input logic         sel_s,
  input logic         ld_s,
  input logic         clr_s,
  input logic [W-1:0] shreg_q,
  input logic [W-1:0] code_o
);

  assert_clear_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !clr_s |=> code_o == '0);

  assert_latch_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ld_s && clr_s) |=> $stable(code_o));

  assert_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!ld_s && clr_s) |=> code_o == $past(shreg_q));

  assert_one_bit_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (shreg_q != $past(shreg_q)) |-> shreg_q[W-1:1] == $past(shreg_q[W-2:0]));

  assert_deselect_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(sel_s) && $past(sel_s, 2)) |-> $stable(shreg_q));

endmodule

bind serdac_front serdac_chk #(.W(W)) u_chk (
  .clk_i  (clk_i),
  .rst_n  (rst_n_q),
  .sel_s  (sel_s),
  .ld_s   (ld_s),
  .clr_s  (clr_s),
  .shreg_q(shreg_q),
  .code_o (code_o)
);

// File: tb/sim_serdac_front.sv
module sim_serdac_front;
  localparam int W    = 12;
  localparam int MV_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sck = 1'b1, sdi = 1'b0, load_n = 1'b1, clear_n = 1'b1;
  logic [W-1:0]    code;
  logic [MV_W-1:0] mv;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] exp_sh = '0;
  logic [W-1:0] exp_code = '0;

  always #4 clk = ~clk;

  serdac_front u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_n_i(sel_n), .sck_i(sck), .sdi_i(sdi),
    .load_n_i(load_n), .clear_n_i(clear_n), .code_o(code), .mv_o(mv)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One bit clocked by the serial clock pin; select is held low by the caller.
  task automatic clk_bit(input logic b);
    sdi = b; sck = 1'b0; settle(4);
    sck = 1'b1; settle(4);
    exp_sh = {exp_sh[W-2:0], b};
  endtask

  task automatic send_word(input logic [W-1:0] w);
    sel_n = 1'b0; settle(4);
    for (int i = W-1; i >= 0; i--) clk_bit(w[i]);
    sel_n = 1'b1; settle(4);
  endtask

  task automatic pulse_load();
    load_n = 1'b0; settle(6);
    exp_code = exp_sh;
    load_n = 1'b1; settle(6);
  endtask

  task automatic t_reset();
    check("R1 code after reset", code, 0);
    check("R1 mv after reset", mv, 0);
    pulse_load();
    check("R1 shift register after reset", code, 0);
  endtask

  task automatic t_track();
    logic [W-1:0] w = 12'hA5C;
    load_n = 1'b0; settle(6);
    sel_n = 1'b0; settle(4);
    for (int i = W-1; i >= 0; i--) begin
      clk_bit(w[i]);
      check("R5 R10 code tracks each bit", code, exp_sh);
    end
    sel_n = 1'b1; settle(4);
    check("R2 word msb first", code, 12'hA5C);
    load_n = 1'b1; settle(6);
    exp_code = exp_sh;
  endtask

  task automatic t_hold();
    logic [W-1:0] w = 12'h3F0;
    sel_n = 1'b0; settle(4);
    for (int i = W-1; i >= 0; i--) begin
      clk_bit(w[i]);
      check("R6 code held with load high", code, exp_code);
    end
    sel_n = 1'b1; settle(4);
    pulse_load();
    check("R6 load transfers new word", code, 12'h3F0);
  endtask

  task automatic t_sel_high();
    sdi = 1'b1;
    for (int k = 0; k < 5; k++) begin
      sck = 1'b0; settle(4);
      sck = 1'b1; settle(4);
    end
    pulse_load();
    check("R4 no shift while deselected", code, 12'h3F0);
  endtask

  task automatic t_sel_clock();
    logic [W-1:0] w = 12'h81F;
    sck = 1'b0; settle(4);
    for (int i = W-1; i >= 0; i--) begin
      sdi = w[i]; sel_n = 1'b0; settle(4);
      sel_n = 1'b1; settle(4);
      exp_sh = {exp_sh[W-2:0], w[i]};
    end
    sck = 1'b1; settle(4);
    pulse_load();
    check("R3 select edges clock data", code, 12'h81F);
  endtask

  task automatic t_scale();
    send_word(12'hFFF); pulse_load();
    check("R9 full scale mv", mv, 4095);
    send_word(12'h800); pulse_load();
    check("R9 midscale mv", mv, 2048);
  endtask

  task automatic t_clr_load_high();
    clear_n = 1'b0; settle(6);
    check("R7 clear with load high", code, 0);
    check("R9 zero mv", mv, 0);
    clear_n = 1'b1; settle(6);
    check("R8 stays zero after clear with load high", code, 0);
    pulse_load();
    check("R7 R8 shift register kept through clear", code, 12'h800);
  endtask

  task automatic t_clr_load_low();
    load_n = 1'b0; settle(6);
    clear_n = 1'b0; settle(6);
    check("R7 clear with load low", code, 0);
    send_word(12'h123);
    check("R7 shifting during clear keeps zero", code, 0);
    clear_n = 1'b1; settle(6);
    check("R8 release with load low takes shift value", code, 12'h123);
    load_n = 1'b1; settle(6);
  endtask

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(4);
    t_reset();
    t_track();
    t_hold();
    t_sel_high();
    t_sel_clock();
    t_scale();
    t_clr_load_high();
    t_clr_load_low();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule